// File: doc/BRIEF.md
# Lite Pixel Format Converter

This block is a streaming colour stage that sits behind the memory fetch of a display layer that does not scale. It takes either packed 4:2:2 YCbCr pixel pairs or narrow ARGB words on a valid/ready input. It delivers one ARGB8888 pixel per transfer on a valid/ready output. Every input pixel yields exactly one output pixel, in order.

For YCbCr input, the chroma of each pair is spread to both pixels by a fixed two-tap interpolator. The result then goes through a YCbCr-to-RGB matrix. Two selects pick the matrix: one chooses between the BT.601 and BT.709 coefficients, the other chooses between full and limited (studio) range. For ARGB input, each narrow channel is widened to 8 bits by bit replication. An end-of-line flag travels with every pixel. The interpolator uses it to close a line without reading into the next one.

The select inputs are taken to be static while pixels are in flight. A change of input format is made only when the stage is empty.

Top module: `pix_lite_cvt`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid_o is 0 and in_ready_o is 1.
- R2: With fmt_i=1 (ARGB4444), in_data_i[15:12]=A, [11:8]=R, [7:4]=G and [3:0]=B. Each 4-bit field v becomes {v,v} in out_argb_o = {A,R,G,B} (bits 31:24 hold A, 7:0 hold B).
- R3: With fmt_i=2 (RGB565), in_data_i[15:11]=R, [10:5]=G and [4:0]=B. Each field is widened by copying its top bits into the new low bits, so all-ones gives 255. Alpha is 255.
- R4: With fmt_i=3 (ARGB8888), in_data_i passes to out_argb_o unchanged.
- R5: With fmt_i=0 (YCbCr 4:2:2), one beat carries a pair laid out as [7:0]=Y0, [15:8]=Cb, [23:16]=Y1 and [31:24]=Cr. The first pixel of the pair uses that pair's own Cb/Cr.
- R6: The second pixel of a pair uses (a+b+1)>>1 of this pair's chroma and the next pair's chroma. If the pair carries in_eol_i, the second pixel reuses this pair's chroma instead. Only that last pixel carries out_eol_o=1.
- R7: The channel values are R=Ky*y+Kr*cr, G=Ky*y-Kgb*cb-Kgr*cr and B=Ky*y+Kb*cb, where cb=Cb-128 and cr=Cr-128. Each coefficient is the real value times 1024, rounded to nearest. Each result has 512 added, is shifted right arithmetically by 10 and is clamped to 0..255. Alpha is 255.
- R8: std_sel_i=0 uses Kr=1.402, Kgb=0.344136, Kgr=0.714136 and Kb=1.772. std_sel_i=1 uses Kr=1.5748, Kgb=0.187324, Kgr=0.468124 and Kb=1.8556.
- R9: lim_rng_i=0 uses y=Y and Ky=1. lim_rng_i=1 uses y=Y-16 and Ky=255/219, and multiplies the chroma coefficients by 255/224.
- R10: With out_ready_i held at 1, an ARGB pixel accepted at clock edge n is first valid at the output after edge n+3.
- R11: While out_valid_o=1 and out_ready_i=0, the output word and flag hold steady and in_ready_o is 0.
- R12: The stage never scales. Each YCbCr pair gives exactly two output pixels and each ARGB beat gives one, in input order, with none lost or repeated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Input format: 0 YCbCr 4:2:2, 1 ARGB4444, 2 RGB565, 3 ARGB8888 |
| std_sel_i | input | 1 | Matrix select: 0 BT.601, 1 BT.709 |
| lim_rng_i | input | 1 | Range select: 0 full, 1 limited |
| in_valid_i | input | 1 | Input beat valid |
| in_data_i | input | 32 | Input pixel or pixel pair |
| in_eol_i | input | 1 | Beat is the last of its line |
| in_ready_o | output | 1 | Stage accepts the beat |
| out_valid_o | output | 1 | Output pixel valid |
| out_argb_o | output | 32 | ARGB8888 output pixel, A in bits 31:24 |
| out_eol_o | output | 1 | Output pixel ends its line |
| out_ready_i | input | 1 | Sink accepts the pixel |

## Verification
A wrong interpolator phase, or a pending pair that is not released, shows as a pixel count that no longer matches the input: an extra pixel or a missing one. The reorder or gap is seen at the very next output pixel, and the stage stalls at the next line end when a line-closing pixel never comes. A wrong coefficient or range select corrupts the colour channels four cycles after the affected pixel enters. A stall bug shows as the word changing, or the input being taken, while the output is held.

// File: rtl/pix_lite_pkg.sv
package pix_lite_pkg;

  typedef enum logic [1:0] {
    FMT_YC422    = 2'd0,
    FMT_A4R4G4B4 = 2'd1,
    FMT_R5G6B5   = 2'd2,
    FMT_A8R8G8B8 = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    logic        yuv;
    logic        std709;
    logic        lim;
    logic        eol;
    logic [7:0]  y;
    logic [7:0]  cb;
    logic [7:0]  cr;
    logic [31:0] argb;
  } pix_tok_t;

  // round(num/den * 2^frac), positive operands only
  function automatic int unsigned fx_coef(longint num, longint den, int frac);
    longint scaled;
    scaled = (num * (longint'(1) << frac) * 2 + den) / (2 * den);
    return int'(scaled);
  endfunction

  function automatic logic [7:0] avg_up(logic [7:0] a, logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b} + 9'd1;
    return s[8:1];
  endfunction

  function automatic logic [31:0] widen(pix_fmt_e fmt, logic [31:0] d);
    case (fmt)
      FMT_A4R4G4B4: return {d[15:12], d[15:12], d[11:8], d[11:8],
                            d[7:4], d[7:4], d[3:0], d[3:0]};
      FMT_R5G6B5:   return {8'hFF, d[15:11], d[15:13], d[10:5], d[10:9],
                            d[4:0], d[4:2]};
      default:      return d;
    endcase
  endfunction

endpackage

// File: rtl/pix_lite_cvt_front.sv
module pix_lite_cvt_front
  import pix_lite_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  pix_fmt_e    fmt_i,
  input  logic        std_sel_i,
  input  logic        lim_rng_i,
  input  logic        in_valid_i,
  input  logic [31:0] in_data_i,
  input  logic        in_eol_i,
  output logic        in_ready_o,
  output pix_tok_t    tok_o,
  output logic        tok_v_o
);

  logic        is_yc, take;
  logic        pend_v_q, pend_v_d, phase_q, phase_d, pend_eol_q;
  logic [31:0] pend_q;
  pix_tok_t    tok_q, tok_d;
  logic        tok_v_q, tok_v_d;

  assign is_yc      = (fmt_i == FMT_YC422);
  // pair slot free, or second pixel waiting for its neighbour
  assign in_ready_o = en_i && (!is_yc || !pend_v_q || phase_q);
  assign take       = in_valid_i && in_ready_o;

  always_comb begin
    tok_d        = tok_q;
    tok_v_d      = 1'b0;
    pend_v_d     = pend_v_q;
    phase_d      = phase_q;
    tok_d.std709 = std_sel_i;
    tok_d.lim    = lim_rng_i;
    if (!is_yc) begin
      tok_v_d    = take;
      tok_d.yuv  = 1'b0;
      tok_d.eol  = in_eol_i;
      tok_d.argb = widen(fmt_i, in_data_i);
    end else begin
      tok_d.yuv  = 1'b1;
      tok_d.argb = '0;
      if (pend_v_q && !phase_q) begin
        tok_v_d  = 1'b1;
        tok_d.y  = pend_q[7:0];
        tok_d.cb = pend_q[15:8];
        tok_d.cr = pend_q[31:24];
        tok_d.eol = 1'b0;
        phase_d  = 1'b1;
      end else if (pend_v_q && phase_q && (pend_eol_q || in_valid_i)) begin
        tok_v_d  = 1'b1;
        tok_d.y  = pend_q[23:16];
        tok_d.eol = pend_eol_q;
        tok_d.cb = pend_eol_q ? pend_q[15:8]  : avg_up(pend_q[15:8],  in_data_i[15:8]);
        tok_d.cr = pend_eol_q ? pend_q[31:24] : avg_up(pend_q[31:24], in_data_i[31:24]);
        pend_v_d = 1'b0;
        phase_d  = 1'b0;
      end
      if (take) begin
        pend_v_d = 1'b1;
        phase_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q      <= '0;
      tok_v_q    <= 1'b0;
      pend_v_q   <= 1'b0;
      phase_q    <= 1'b0;
      pend_q     <= '0;
      pend_eol_q <= 1'b0;
    end else if (en_i) begin
      tok_q    <= tok_d;
      tok_v_q  <= tok_v_d;
      pend_v_q <= pend_v_d;
      phase_q  <= phase_d;
      if (take && is_yc) begin
        pend_q     <= in_data_i;
        pend_eol_q <= in_eol_i;
      end
    end
  end

  assign tok_o   = tok_q;
  assign tok_v_o = tok_v_q;

endmodule

// File: rtl/pix_lite_cvt_csc.sv
module pix_lite_cvt_csc
  import pix_lite_pkg::*;
#(
  parameter int FRAC = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  pix_tok_t    tok_i,
  input  logic        tok_v_i,
  output logic        out_v_o,
  output logic [31:0] out_argb_o,
  output logic        out_eol_o
);

  localparam int CW   = FRAC + 3;
  localparam int AW   = CW + 12;
  localparam int NCH  = 3;
  localparam int unsigned ONE  = 1 << FRAC;
  localparam int unsigned HALF = 1 << (FRAC - 1);
  localparam longint DF = 1000000;
  localparam longint DL = 224000000;

  // index {std709, lim}
  localparam int unsigned K_Y  [4] = '{ONE, fx_coef(255, 219, FRAC), ONE, fx_coef(255, 219, FRAC)};
  localparam int unsigned K_R  [4] = '{fx_coef(1402000, DF, FRAC), fx_coef(longint'(1402000) * 255, DL, FRAC),
                                       fx_coef(1574800, DF, FRAC), fx_coef(longint'(1574800) * 255, DL, FRAC)};
  localparam int unsigned K_GB [4] = '{fx_coef(344136, DF, FRAC), fx_coef(longint'(344136) * 255, DL, FRAC),
                                       fx_coef(187324, DF, FRAC), fx_coef(longint'(187324) * 255, DL, FRAC)};
  localparam int unsigned K_GR [4] = '{fx_coef(714136, DF, FRAC), fx_coef(longint'(714136) * 255, DL, FRAC),
                                       fx_coef(468124, DF, FRAC), fx_coef(longint'(468124) * 255, DL, FRAC)};
  localparam int unsigned K_B  [4] = '{fx_coef(1772000, DF, FRAC), fx_coef(longint'(1772000) * 255, DL, FRAC),
                                       fx_coef(1855600, DF, FRAC), fx_coef(longint'(1855600) * 255, DL, FRAC)};

  logic [1:0] sel;
  logic signed [9:0]    yd, cbd, crd;
  logic signed [CW-1:0] ky, kr, kgb, kgr, kb;

  assign sel = {tok_i.std709, tok_i.lim};
  assign yd  = $signed({2'b00, tok_i.y}) - (tok_i.lim ? 10'sd16 : 10'sd0);
  assign cbd = $signed({2'b00, tok_i.cb}) - 10'sd128;
  assign crd = $signed({2'b00, tok_i.cr}) - 10'sd128;
  assign ky  = $signed(CW'(K_Y[sel]));
  assign kr  = $signed(CW'(K_R[sel]));
  assign kgb = $signed(CW'(K_GB[sel]));
  assign kgr = $signed(CW'(K_GR[sel]));
  assign kb  = $signed(CW'(K_B[sel]));

  // stage 1: products
  logic signed [AW-1:0] p_y_q, p_r_q, p_gb_q, p_gr_q, p_b_q;
  logic        s1_v_q, s1_yuv_q, s1_eol_q;
  logic [31:0] s1_argb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {p_y_q, p_r_q, p_gb_q, p_gr_q, p_b_q} <= '0;
      {s1_v_q, s1_yuv_q, s1_eol_q} <= '0;
      s1_argb_q <= '0;
    end else if (en_i) begin
      p_y_q     <= AW'(yd)  * AW'(ky);
      p_r_q     <= AW'(crd) * AW'(kr);
      p_gb_q    <= AW'(cbd) * AW'(kgb);
      p_gr_q    <= AW'(crd) * AW'(kgr);
      p_b_q     <= AW'(cbd) * AW'(kb);
      s1_v_q    <= tok_v_i;
      s1_yuv_q  <= tok_i.yuv;
      s1_eol_q  <= tok_i.eol;
      s1_argb_q <= tok_i.argb;
    end
  end

  // stage 2: sums
  logic signed [AW-1:0] sum_q [NCH];
  logic        s2_v_q, s2_yuv_q, s2_eol_q;
  logic [31:0] s2_argb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) sum_q[i] <= '0;
      {s2_v_q, s2_yuv_q, s2_eol_q} <= '0;
      s2_argb_q <= '0;
    end else if (en_i) begin
      sum_q[0]  <= p_y_q + p_r_q;
      sum_q[1]  <= p_y_q - p_gb_q - p_gr_q;
      sum_q[2]  <= p_y_q + p_b_q;
      s2_v_q    <= s1_v_q;
      s2_yuv_q  <= s1_yuv_q;
      s2_eol_q  <= s1_eol_q;
      s2_argb_q <= s1_argb_q;
    end
  end

  // stage 3: round, clamp, select
  logic [7:0] chan [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_clamp
    logic signed [AW-1:0] rnd, shf;
    assign rnd = sum_q[c] + AW'(HALF);
    assign shf = rnd >>> FRAC;
    always_comb begin
      if (shf[AW-1])          chan[c] = 8'h00;
      else if (|shf[AW-2:8])  chan[c] = 8'hFF;
      else                    chan[c] = shf[7:0];
    end
  end

  logic        s3_v_q, s3_eol_q;
  logic [31:0] s3_argb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_v_q    <= 1'b0;
      s3_eol_q  <= 1'b0;
      s3_argb_q <= '0;
    end else if (en_i) begin
      s3_v_q    <= s2_v_q;
      s3_eol_q  <= s2_eol_q;
      s3_argb_q <= s2_yuv_q ? {8'hFF, chan[0], chan[1], chan[2]} : s2_argb_q;
    end
  end

  assign out_v_o    = s3_v_q;
  assign out_argb_o = s3_argb_q;
  assign out_eol_o  = s3_eol_q;

endmodule

// File: rtl/pix_lite_cvt.sv
module pix_lite_cvt
  import pix_lite_pkg::*;
#(
  parameter int FRAC = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  fmt_i,
  input  logic        std_sel_i,
  input  logic        lim_rng_i,
  input  logic        in_valid_i,
  input  logic [31:0] in_data_i,
  input  logic        in_eol_i,
  output logic        in_ready_o,
  output logic        out_valid_o,
  output logic [31:0] out_argb_o,
  output logic        out_eol_o,
  input  logic        out_ready_i
);

  logic     en, tok_v;
  pix_tok_t tok;

  // single stall for every stage
  assign en = !out_valid_o || out_ready_i;

  pix_lite_cvt_front u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .fmt_i      (pix_fmt_e'(fmt_i)),
    .std_sel_i  (std_sel_i),
    .lim_rng_i  (lim_rng_i),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_eol_i   (in_eol_i),
    .in_ready_o (in_ready_o),
    .tok_o      (tok),
    .tok_v_o    (tok_v)
  );

  pix_lite_cvt_csc #(.FRAC(FRAC)) u_csc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .tok_i      (tok),
    .tok_v_i    (tok_v),
    .out_v_o    (out_valid_o),
    .out_argb_o (out_argb_o),
    .out_eol_o  (out_eol_o)
  );

endmodule

// File: rtl/pix_lite_cvt_chk.sv
module pix_lite_cvt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  fmt_i,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic [31:0] out_argb_o,
  input logic        out_eol_o,
  input logic        out_ready_i
);

  logic [3:0] inflight_q;
  logic       in_hs, out_hs;

  assign in_hs  = in_valid_i && in_ready_o;
  assign out_hs = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else inflight_q <= inflight_q + (in_hs ? ((fmt_i == 2'd0) ? 4'd2 : 4'd1) : 4'd0)
                                  - (out_hs ? 4'd1 : 4'd0);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_idle: assert (!out_valid_o);
  end

  a_r11_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_argb_o) && $stable(out_eol_o)));

  a_r11_block_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  a_r12_no_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (inflight_q != 4'd0));

  a_r12_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= 4'd6);

endmodule

bind pix_lite_cvt pix_lite_cvt_chk chk_i (.*);

// File: tb/pix_lite_cvt_tb_top.sv
`timescale 1ns/1ps
module pix_lite_cvt_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd3;
  logic        std_sel = 1'b0, lim_rng = 1'b0;
  logic        in_valid = 1'b0, in_eol = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_eol;
  logic [31:0] out_argb;
  logic        out_ready = 1'b1;

  int n_vec = 0, n_bad = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [32:0] exp_q [$];
  string       tag_q [$];
  bit          prev_hold = 0;
  logic [32:0] prev_word = '0;
  bit          done = 0;

  always #2 clk = ~clk;

  pix_lite_cvt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .std_sel_i(std_sel), .lim_rng_i(lim_rng),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_eol_i(in_eol), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_argb_o(out_argb), .out_eol_o(out_eol), .out_ready_i(out_ready)
  );

  task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  function automatic int clip8(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  // R7 R8 R9 reference
  function automatic logic [31:0] ref_yuv(int y, int cb, int cr, bit s709, bit lim);
    real sc, kr, kgb, kgr, kb;
    int  ky, ir, igb, igr, ib, yd, cbd, crd, r, g, b;
    sc  = lim ? 255.0 / 224.0 : 1.0;
    kr  = s709 ? 1.5748   : 1.402;
    kgb = s709 ? 0.187324 : 0.344136;
    kgr = s709 ? 0.468124 : 0.714136;
    kb  = s709 ? 1.8556   : 1.772;
    ky  = lim ? $rtoi(255.0 / 219.0 * 1024.0 + 0.5) : 1024;
    ir  = $rtoi(kr  * sc * 1024.0 + 0.5);
    igb = $rtoi(kgb * sc * 1024.0 + 0.5);
    igr = $rtoi(kgr * sc * 1024.0 + 0.5);
    ib  = $rtoi(kb  * sc * 1024.0 + 0.5);
    yd  = y - (lim ? 16 : 0);
    cbd = cb - 128;
    crd = cr - 128;
    r = clip8((ky * yd + ir * crd + 512) >>> 10);
    g = clip8((ky * yd - igb * cbd - igr * crd + 512) >>> 10);
    b = clip8((ky * yd + ib * cbd + 512) >>> 10);
    return {8'hFF, r[7:0], g[7:0], b[7:0]};
  endfunction

  // R2 R3 R4 reference
  function automatic logic [31:0] ref_argb(logic [1:0] f, logic [31:0] d);
    int a, r, g, b;
    case (f)
      2'd1: begin
        a = d[15:12] * 17; r = d[11:8] * 17; g = d[7:4] * 17; b = d[3:0] * 17;
      end
      2'd2: begin
        a = 255;
        r = (int'(d[15:11]) << 3) | (int'(d[15:11]) >> 2);
        g = (int'(d[10:5])  << 2) | (int'(d[10:5])  >> 4);
        b = (int'(d[4:0])   << 3) | (int'(d[4:0])   >> 2);
      end
      default: return d;
    endcase
    return {a[7:0], r[7:0], g[7:0], b[7:0]};
  endfunction

  task automatic drive(input logic [31:0] d, input logic e);
    in_data = d; in_eol = e; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_argb(input logic [31:0] d, input logic e, input string tag);
    exp_q.push_back({e, ref_argb(fmt, d)});
    tag_q.push_back(tag);
    drive(d, e);
  endtask

  task automatic send_line(input logic [31:0] pr [4], input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int cb, cr, cbo, cro;
      cb = pr[k][15:8]; cr = pr[k][31:24];
      if (k == n - 1) begin cbo = cb; cro = cr; end
      else begin
        cbo = (cb + int'(pr[k+1][15:8]) + 1) >> 1;
        cro = (cr + int'(pr[k+1][31:24]) + 1) >> 1;
      end
      exp_q.push_back({1'b0, ref_yuv(pr[k][7:0], cb, cr, std_sel, lim_rng)});
      tag_q.push_back({tag, " even"});
      exp_q.push_back({k == n - 1, ref_yuv(pr[k][23:16], cbo, cro, std_sel, lim_rng)});
      tag_q.push_back({tag, " odd"});
    end
    for (int k = 0; k < n; k++) drive(pr[k], k == n - 1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // sink readiness
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[3];
      default: out_ready = 1'b0;
    endcase
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_hold)
        check(out_valid && ({out_eol, out_argb} == prev_word), "R11 held output",
              {out_eol, out_argb}, prev_word);
      prev_hold = out_valid && !out_ready;
      prev_word = {out_eol, out_argb};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R12 extra pixel", {out_eol, out_argb}, '0);
        else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_eol, out_argb} == e, t, {out_eol, out_argb}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R12 watchdog expired", '0, '0);
    summary();
  end

  initial begin
    logic [31:0] ln [4];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1 valid in reset", {32'd0, out_valid}, 33'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 idle after reset", {31'd0, out_valid, in_ready}, 33'd1);
    @(posedge clk); #1;

    // R10 latency
    fmt = 2'd3; rdy_mode = 0;
    @(posedge clk); #1;
    send_argb(32'h1234_5678, 1'b1, "R10 R4 single pixel");
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R10 not before edge n+3", {32'd0, out_valid}, 33'd0);
    @(negedge clk);
    check(out_valid, "R10 valid after edge n+3", {32'd0, out_valid}, 33'd1);
    @(posedge clk); #1;
    drain();

    rdy_mode = 1;
    for (int i = 0; i < 8; i++) send_argb($urandom, i == 7, "R4 pass-through");
    drain();

    fmt = 2'd1;
    send_argb(32'h0000_FFFF, 1'b0, "R2 all ones");
    send_argb(32'h0000_0000, 1'b0, "R2 all zeros");
    for (int i = 0; i < 8; i++) send_argb($urandom, i == 7, "R2 ARGB4444");
    drain();

    fmt = 2'd2;
    send_argb(32'h0000_FFFF, 1'b0, "R3 all ones");
    send_argb(32'h0000_F800, 1'b0, "R3 red only");
    for (int i = 0; i < 8; i++) send_argb($urandom, i == 7, "R3 RGB565");
    drain();

    fmt = 2'd0;
    for (int m = 0; m < 4; m++) begin
      std_sel = m[1]; lim_rng = m[0];
      @(posedge clk); #1;
      ln[0] = 32'h80_10_80_10; ln[1] = 32'hFF_EB_00_EB;
      ln[2] = 32'h00_00_FF_FF; ln[3] = 32'h40_7F_C0_80;
      send_line(ln, 4, "R5 R6 R7 R8 R9 fixed line");
      for (int k = 0; k < 4; k++) ln[k] = $urandom;
      send_line(ln, 4, "R7 R8 R9 random line");
      ln[0] = $urandom;
      send_line(ln, 1, "R6 one-pair line");
      drain();
    end

    // R11 stall
    fmt = 2'd3; rdy_mode = 2;
    @(posedge clk); #1;
    fork
      for (int i = 0; i < 6; i++) send_argb($urandom, i == 5, "R11 R12 after stall");
      begin
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(out_valid && !in_ready, "R11 input blocked", {31'd0, out_valid, in_ready}, 33'd2);
        rdy_mode = 0;
      end
    join
    drain();
    check(exp_q.size() == 0, "R12 all pixels delivered", 33'(exp_q.size()), 33'd0);
    done = 1;
    summary();
  end

endmodule